// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block connects a processor-side request port to an asynchronous DRAM that takes its address in two halves over one set of pins. The processor places a full byte address and a read/write flag on its inputs, then raises a request and holds it. The controller drives the high part of the address (the row) onto the shared address bus with the row strobe. It then drives the low part (the column) with the column strobe, and answers with a one-cycle completion pulse. Data lines run directly between processor and memory and do not pass through the block.

A free-running interval timer marks when the next row is due for refresh. A row counter supplies the row numbers in ascending order. A refresh is a row-strobe-only cycle: opening a row restores every cell in it. A due refresh is served before a waiting processor request, but it never interrupts an access that has already started. Every strobe and the address bus come straight from flip-flops.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, ras_n, cas_n and cs_n are high and mem_done is low.
- R2: An access drives the upper ROW_W address bits on mem_addr as ras_n falls. After exactly T_RCD cycles with ras_n low, it drives the lower COL_W bits (zero-extended) as cas_n falls. cas_n is low only while ras_n is low, and mem_addr is stable while cas_n stays low.
- R3: During an access, mem_rw is 1 for a read (wr_en=0) and 0 for a write (wr_en=1). cs_n is low whenever ras_n is low.
- R4: cas_n stays low for T_CAS cycles. mem_done is a single-cycle pulse in the cycle right after cas_n rises. With no refresh in between, it is seen T_RCD+T_CAS+1 cycles after req is first sampled in the idle state.
- R5: A refresh is a cycle in which ras_n is low for T_RAS cycles, cas_n stays high and mem_rw stays 1. The rows refreshed run 0,1,2,... and wrap after 2^ROW_W.
- R6: With no processor traffic, consecutive refresh cycles start exactly REFRESH_INTERVAL cycles apart.
- R7: When a refresh is due and a request is waiting in the same idle cycle, the refresh goes first. A refresh never starts inside an access.
- R8: No refresh tick is lost: after N full intervals at least N-1 refreshes have run, and never more than N. Every request completes.
- R9: ras_n stays high for at least T_RP cycles between any two strobe cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until mem_done |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+COL_W | Full byte address (row in upper bits) |
| mem_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| mem_rw | output | 1 | High for read, low for write |
| cs_n | output | 1 | Chip select, active low |

## Verification
A corrupted sequencer state shows within one access at the strobes: a wrong ras-to-cas gap, a column strobe outside a row strobe, or a missing or doubled completion pulse. A faulty address split shows as a wrong row or column value at the first strobe fall of the next access. A wrong refresh row counter shows as an out-of-order row at the next refresh. A timer or pending-flag fault shows as a wrong refresh spacing in the first idle interval, or as a refresh count that falls behind the elapsed time by the end of the run.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACT  = 3'd1,
    ST_COL  = 3'd2,
    ST_DONE = 3'd3,
    ST_REF  = 3'd4,
    ST_PRE  = 3'd5
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int MUX_W = 12
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  output logic [MUX_W-1:0]       row_bus,
  output logic [MUX_W-1:0]       col_bus
);
  always_comb begin
    row_bus = '0;
    col_bus = '0;
    row_bus[ROW_W-1:0] = addr[ROW_W+COL_W-1:COL_W];
    col_bus[COL_W-1:0] = addr[COL_W-1:0];
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W            = 12,
  parameter int MUX_W            = 12,
  parameter int REFRESH_INTERVAL = 2078
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant,
  output logic             pending,
  output logic [MUX_W-1:0] row_bus
);
  localparam int TW = $clog2(REFRESH_INTERVAL + 1);
  localparam logic [TW-1:0] LAST = TW'(REFRESH_INTERVAL - 1);

  logic [TW-1:0]    tmr;
  logic [ROW_W-1:0] row_ctr;
  logic             tick;

  assign tick = (tmr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr     <= '0;
      pending <= 1'b0;
      row_ctr <= '0;
    end else begin
      tmr     <= tick ? '0 : tmr + 1'b1;
      pending <= (pending & ~grant) | tick;
      if (grant) row_ctr <= row_ctr + 1'b1;
    end
  end

  always_comb begin
    row_bus = '0;
    row_bus[ROW_W-1:0] = row_ctr;
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_mux_pkg::*;
#(
  parameter int MUX_W = 12,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RAS = 3,
  parameter int T_RP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             wr_en,
  input  logic             ref_pend,
  input  logic [MUX_W-1:0] row_in,
  input  logic [MUX_W-1:0] col_in,
  input  logic [MUX_W-1:0] ref_row,
  output logic             acc_grant,
  output logic             ref_grant,
  output logic             mem_done,
  output logic [MUX_W-1:0] mem_addr,
  output logic             ras_n,
  output logic             cas_n,
  output logic             mem_rw,
  output logic             cs_n
);
  localparam int TMAX = max2(max2(T_RCD, T_CAS), max2(T_RAS, T_RP));
  localparam int CW   = $clog2(TMAX + 1);

  seq_state_t       state, nxt;
  logic [CW-1:0]    cnt;
  logic [MUX_W-1:0] col_q;
  logic             strobe_on;

  always_comb begin
    nxt       = state;
    acc_grant = 1'b0;
    ref_grant = 1'b0;
    case (state)
      ST_IDLE: begin
        if (ref_pend) begin
          ref_grant = 1'b1;
          nxt       = ST_REF;
        end else if (req) begin
          acc_grant = 1'b1;
          nxt       = ST_ACT;
        end
      end
      ST_ACT:  if (cnt == CW'(T_RCD - 1)) nxt = ST_COL;
      ST_COL:  if (cnt == CW'(T_CAS - 1)) nxt = ST_DONE;
      ST_DONE: nxt = ST_PRE;
      ST_REF:  if (cnt == CW'(T_RAS - 1)) nxt = ST_PRE;
      ST_PRE:  if (cnt == CW'(T_RP - 1))  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign strobe_on = (nxt == ST_ACT) || (nxt == ST_COL) || (nxt == ST_REF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      col_q    <= '0;
      mem_addr <= '0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      cs_n     <= 1'b1;
      mem_rw   <= 1'b1;
      mem_done <= 1'b0;
    end else begin
      state    <= nxt;
      cnt      <= (nxt != state) ? '0 : cnt + 1'b1;
      ras_n    <= ~strobe_on;
      cs_n     <= ~strobe_on;
      cas_n    <= ~(nxt == ST_COL);
      mem_done <= (nxt == ST_DONE);
      if (acc_grant) begin
        mem_addr <= row_in;
        col_q    <= col_in;
        mem_rw   <= ~wr_en;
      end else if (ref_grant) begin
        mem_addr <= ref_row;
        mem_rw   <= 1'b1;
      end else if (state == ST_ACT && nxt == ST_COL) begin
        mem_addr <= col_q;
      end else if (nxt == ST_IDLE) begin
        mem_rw   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dram_mux_pkg::*;
#(
  parameter int ROW_W            = 12,
  parameter int COL_W            = 9,
  parameter int REFRESH_INTERVAL = 2078,
  parameter int T_RCD            = 2,
  parameter int T_CAS            = 2,
  parameter int T_RAS            = 3,
  parameter int T_RP             = 2,
  localparam int ADDR_W          = ROW_W + COL_W,
  localparam int MUX_W           = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_done,
  output logic [MUX_W-1:0]  mem_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              mem_rw,
  output logic              cs_n
);
  logic [MUX_W-1:0] row_bus, col_bus, ref_row;
  logic             ref_pend, ref_grant, acc_grant;

  dram_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_split (
    .addr(addr), .row_bus(row_bus), .col_bus(col_bus)
  );

  dram_refresh_sched #(.ROW_W(ROW_W), .MUX_W(MUX_W),
                       .REFRESH_INTERVAL(REFRESH_INTERVAL)) u_refresh (
    .clk(clk), .rst(rst), .grant(ref_grant),
    .pending(ref_pend), .row_bus(ref_row)
  );

  dram_seq #(.MUX_W(MUX_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
             .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk(clk), .rst(rst), .req(req), .wr_en(wr_en),
    .ref_pend(ref_pend), .row_in(row_bus), .col_in(col_bus),
    .ref_row(ref_row), .acc_grant(acc_grant), .ref_grant(ref_grant),
    .mem_done(mem_done), .mem_addr(mem_addr), .ras_n(ras_n),
    .cas_n(cas_n), .mem_rw(mem_rw), .cs_n(cs_n)
  );
endmodule

// File: rtl/dram_mux_ctrl_checker.sv
module dram_mux_ctrl_checker #(
  parameter int MUX_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ras_n,
  input logic             cas_n,
  input logic             cs_n,
  input logic             mem_rw,
  input logic             mem_done,
  input logic [MUX_W-1:0] mem_addr,
  input logic             ref_pend,
  input logic             acc_grant,
  input logic             ref_grant
);
  assert_cas_inside_ras_R2: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  assert_col_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && !$past(cas_n)) |-> $stable(mem_addr));

  assert_cs_with_ras_R3: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !cs_n);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    mem_done |=> !mem_done);

  assert_done_after_cas_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_n) |-> mem_done);

  assert_refresh_ras_only_R5: assert property (@(posedge clk) disable iff (rst)
    ref_grant |=> (!ras_n && cas_n && mem_rw));

  assert_refresh_first_R7: assert property (@(posedge clk) disable iff (rst)
    !(ref_pend && acc_grant));

  assert_grant_when_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_grant || ref_grant) |-> (ras_n && cas_n));
endmodule

bind dram_mux_ctrl dram_mux_ctrl_checker #(.MUX_W(MUX_W)) u_checker (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .cs_n(cs_n),
  .mem_rw(mem_rw), .mem_done(mem_done), .mem_addr(mem_addr),
  .ref_pend(ref_pend), .acc_grant(acc_grant), .ref_grant(ref_grant)
);

// File: tb/dram_mux_ctrl_test.sv
`timescale 1ns/1ps
module dram_mux_ctrl_test;
  localparam int ROW_W = 3;
  localparam int COL_W = 2;
  localparam int REFI  = 40;
  localparam int T_RCD = 2;
  localparam int T_CAS = 2;
  localparam int T_RAS = 3;
  localparam int T_RP  = 1;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int BASE_LAT = T_RCD + T_CAS + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic mem_done, ras_n, cas_n, mem_rw, cs_n;
  logic [MUX_W-1:0] mem_addr;

  always #2 clk = ~clk;

  dram_mux_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .REFRESH_INTERVAL(REFI),
                  .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)) uut (
    .clk(clk), .rst(rst), .req(req), .wr_en(wr_en), .addr(addr),
    .mem_done(mem_done), .mem_addr(mem_addr), .ras_n(ras_n),
    .cas_n(cas_n), .mem_rw(mem_rw), .cs_n(cs_n)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit running = 1'b0;
  bit idle_phase = 1'b0;
  bit ref_seen = 1'b0;
  int completed = 0;

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // passive memory-side monitor
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int low_cnt = 0, high_cnt = 0;
  bit saw_cas = 1'b0, rw_low = 1'b0, any_cycle = 1'b0;
  int cyc_row = 0;
  int exp_ref_row = 0;
  int refreshes = 0;
  int last_ref_start = -1;
  int cur_start = 0;

  always @(negedge clk) begin
    if (running) begin
      cyc++;
      if (prev_ras && !ras_n) begin
        if (any_cycle)
          chk(high_cnt >= T_RP, "R9 precharge", high_cnt, T_RP);
        chk(cs_n == 1'b0, "R3 cs_n low with ras", cs_n, 0);
        any_cycle = 1'b1;
        cyc_row = int'(mem_addr);
        low_cnt = 1;
        saw_cas = 1'b0;
        rw_low = !mem_rw;
        cur_start = cyc;
      end else if (!ras_n) begin
        low_cnt++;
        if (!mem_rw) rw_low = 1'b1;
      end
      if (!ras_n && prev_cas && !cas_n) begin
        saw_cas = 1'b1;
        chk(cyc_row == int'(addr >> COL_W), "R2 row address", cyc_row, int'(addr >> COL_W));
        chk(int'(mem_addr) == int'(addr % (1 << COL_W)), "R2 column address",
            int'(mem_addr), int'(addr % (1 << COL_W)));
        chk(low_cnt == T_RCD + 1, "R2 ras-to-cas gap", low_cnt - 1, T_RCD);
        chk(mem_rw == !wr_en, "R3 mem_rw polarity", mem_rw, !wr_en);
      end
      if (!prev_ras && ras_n) begin
        high_cnt = 1;
        if (!saw_cas) begin
          refreshes++;
          ref_seen = 1'b1;
          chk(cyc_row == exp_ref_row, "R5 refresh row order", cyc_row, exp_ref_row);
          chk(low_cnt == T_RAS, "R5 refresh ras width", low_cnt, T_RAS);
          chk(!rw_low, "R5 refresh keeps mem_rw high", rw_low, 0);
          exp_ref_row = (exp_ref_row + 1) % (1 << ROW_W);
          if (idle_phase && last_ref_start >= 0)
            chk(cur_start - last_ref_start == REFI, "R6 idle refresh spacing",
                cur_start - last_ref_start, REFI);
          last_ref_start = cur_start;
        end
      end else if (ras_n) begin
        high_cnt++;
      end
      if (cyc > 20000) begin
        chk(1'b0, "watchdog", cyc, 20000);
        finish_run();
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic access(input int a, input bit w);
    int lat;
    @(negedge clk);
    @(negedge clk);
    addr  = ADDR_W'(a);
    wr_en = w;
    ref_seen = 1'b0;
    req = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!mem_done && lat < 200);
    req = 1'b0;
    chk(mem_done == 1'b1, "R8 access completes", mem_done, 1);
    if (mem_done) completed++;
    if (!ref_seen)
      chk(lat == BASE_LAT, "R4 completion latency", lat, BASE_LAT);
    else
      chk(lat > BASE_LAT && lat <= BASE_LAT + T_RAS + T_RP + 1,
          "R7 refresh served before request", lat, BASE_LAT + T_RAS + T_RP);
    @(negedge clk);
    chk(mem_done == 1'b0, "R4 completion is one cycle", mem_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && cs_n && !mem_done, "R1 reset state",
        {ras_n, cas_n, cs_n, mem_done}, 4'b1110);
    rst = 1'b0;
    running = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && cs_n && !mem_done, "R1 state after reset",
        {ras_n, cas_n, cs_n, mem_done}, 4'b1110);
    idle_phase = 1'b1;
    repeat (5 * REFI) @(negedge clk);
    idle_phase = 1'b0;
    chk(refreshes >= 4, "R6 refreshes while idle", refreshes, 4);
    for (int w = 0; w < 2; w++)
      for (int a = 0; a < (1 << ADDR_W); a++)
        access(a, w[0]);
    chk(completed == 2 * (1 << ADDR_W), "R8 all accesses done",
        completed, 2 * (1 << ADDR_W));
    chk(refreshes >= cyc / REFI - 1 && refreshes <= cyc / REFI,
        "R8 no refresh lost", refreshes, cyc / REFI);
    finish_run();
  end
endmodule